// File: doc/BRIEF.md
# Local Countdown Interrupt Timer

A per-core countdown timer that software controls through four word registers on a plain memory-mapped write/read bus. Writing a start value arms the timer and begins the countdown at once. The countdown runs on a prescaled copy of the bus clock. When it reaches zero, the block issues a one-cycle interrupt request that carries a programmed 8-bit vector, unless the vector entry is masked.

A separate vector entry holds the vector, a mask bit and a repeat bit. Because of this, the counter can run with its interrupt masked, and software can read the live count twice to measure elapsed ticks, for example to calibrate the bus clock against another time base. In repeat mode the counter reloads its start value and runs again. In single mode it stops at zero. To shut the timer down, software sets the mask and leaves a non-zero vector in place.

Register map by word address (`bus_addr`):
- 0, vector entry: bits [7:0] vector, bit 16 mask, bit 17 repeat. All other bits read as zero.
- 1, start value.
- 2, live count. This register is read-only.
- 3, prescale select. Bits 3, 1 and 0 form the code {b3,b1,b0}. Bit 2 is kept but has no effect. Bits above 3 read as zero.

The interrupt outputs are plain pins with no handshake. Every register write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `ltmr_top`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked, single mode, vector 0). The start value, the live count and the prescale select all read 0, and `irq_req` is low.
- R2: A write to address 1 loads the written value into the live count at that edge and restarts the prescaler. A write while the timer is running restarts the countdown from the new value.
- R3: Address 2 reads the live count as it decrements. Writes to address 2 have no effect on any register.
- R4: The count steps down once every D active cycles. The code {b3,b1,b0} selects D: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. The first `irq_req` therefore appears N·D cycles after the edge that writes start value N.
- R5: In single mode (bit 17 = 0) the count stops at zero and stays there, and no further request is raised until address 1 is written again.
- R6: In repeat mode (bit 17 = 1) the live count reloads the start value on the cycle after it reaches zero. Successive requests are N·D+1 cycles apart.
- R7: With the mask bit (bit 16) set, the count keeps running and reloading, but `irq_req` stays low.
- R8: `irq_req` is high for exactly one cycle per unmasked expiry. During that cycle `irq_vector` equals the vector held in the entry at the expiry edge, and the live count reads 0. At all other times `irq_vector` is 0.
- R9: Writing a start value of 0 stops the count at 0 with no request, even in repeat mode.
- R10: The prescale select register keeps bits [3:0] as written, and bits above 3 read as zero. Bit 2 has no effect on the count rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq_req`, zero otherwise |

## Verification
On every cycle, the assertions check the following:
- a request lasts a single cycle, coincides with a zero count, and carries the vector that was held at the expiry;
- a request is never raised while the entry is masked;
- the count only holds or steps down by one;
- a single-mode timer at zero stays there;
- a start-value write lands in the count on the next cycle.

The exact timing needs the bench's scenarios: the N·D latency for each prescale code, the N·D+1 repeat period, restart on rewrite, the zero-value stop, and the read-back of every register, including bit 2 of the prescale select being kept but having no effect. The bench's reference model also compares the outputs and the read data on every clock.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  localparam int VEC_W  = 8;
  localparam int PRE_W  = 7;   // wide enough for a limit of 127 (divide by 128)

  localparam int OFS_ENTRY = 0;
  localparam int OFS_START = 1;
  localparam int OFS_LIVE  = 2;
  localparam int OFS_PRESC = 3;

  localparam int BIT_MASK   = 16;
  localparam int BIT_REPEAT = 17;

  typedef struct packed {
    logic             repeat_en;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } vec_entry_t;

  // Last prescaler count value before a tick, from the 3-bit select code.
  function automatic logic [PRE_W-1:0] presc_limit(input logic [2:0] code);
    logic [7:0] t;
    if (code == 3'b111) begin
      t = 8'd0;
    end else begin
      t = (8'd1 << ({1'b0, code} + 4'd1)) - 8'd1;
    end
    return t[PRE_W-1:0];
  endfunction

endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import ltmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [COUNT_W-1:0] live_count,
  output vec_entry_t         entry,
  output logic [COUNT_W-1:0] start_value,
  output logic [2:0]         presc_code,
  output logic               start_wr,
  output logic               presc_wr,
  output logic [DATA_W-1:0]  bus_rdata
);

  localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'(OFS_ENTRY);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFS_LIVE);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);

  logic       entry_wr;
  logic [3:0] presc_q;

  assign entry_wr = bus_wr && (bus_addr == A_ENTRY);
  assign start_wr = bus_wr && (bus_addr == A_START);
  assign presc_wr = bus_wr && (bus_addr == A_PRESC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry.repeat_en <= 1'b0;
      entry.mask      <= 1'b1;
      entry.vector    <= '0;
    end else if (entry_wr) begin
      entry.repeat_en <= bus_wdata[BIT_REPEAT];
      entry.mask      <= bus_wdata[BIT_MASK];
      entry.vector    <= bus_wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_value <= '0;
    end else if (start_wr) begin
      start_value <= bus_wdata[COUNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (presc_wr) begin
      presc_q <= bus_wdata[3:0];
    end
  end

  assign presc_code = {presc_q[3], presc_q[1:0]};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ENTRY: begin
        bus_rdata[VEC_W-1:0] = entry.vector;
        bus_rdata[BIT_MASK]  = entry.mask;
        bus_rdata[BIT_REPEAT] = entry.repeat_en;
      end
      A_START: bus_rdata[COUNT_W-1:0] = start_value;
      A_LIVE:  bus_rdata[COUNT_W-1:0] = live_count;
      A_PRESC: bus_rdata[3:0] = presc_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
  import ltmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       active,
  input  logic [2:0] code,
  output logic       tick
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit = presc_limit(code);
  // ">=" keeps a smaller limit safe if the select changes under a running count.
  assign tick  = active && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || !active || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_value,
  input  logic [COUNT_W-1:0] start_value,
  input  logic               repeat_en,
  input  logic               tick,
  output logic [COUNT_W-1:0] count,
  output logic               hit_zero,
  output logic               reload,
  output logic               active
);

  logic expired_q;

  assign active   = (count != '0);
  assign hit_zero = !load && tick && (count == COUNT_W'(1));
  assign reload   = !load && expired_q && repeat_en && (start_value != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      expired_q <= 1'b0;
    end else if (load) begin
      count     <= load_value;
      expired_q <= 1'b0;
    end else if (reload) begin
      count     <= start_value;
      expired_q <= 1'b0;
    end else if (tick && active) begin
      count     <= count - COUNT_W'(1);
      expired_q <= hit_zero;
    end else begin
      expired_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);

  vec_entry_t         entry;
  logic [COUNT_W-1:0] start_value;
  logic [COUNT_W-1:0] live_count;
  logic [2:0]         presc_code;
  logic               start_wr;
  logic               presc_wr;
  logic               tick;
  logic               hit_zero;
  logic               reload;
  logic               active;
  logic               lvt_mask;
  logic               lvt_repeat;
  logic [VEC_W-1:0]   lvt_vector;

  assign lvt_mask   = entry.mask;
  assign lvt_repeat = entry.repeat_en;
  assign lvt_vector = entry.vector;

  ltmr_regs #(
    .DATA_W (DATA_W),
    .COUNT_W(COUNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .live_count (live_count),
    .entry      (entry),
    .start_value(start_value),
    .presc_code (presc_code),
    .start_wr   (start_wr),
    .presc_wr   (presc_wr),
    .bus_rdata  (bus_rdata)
  );

  ltmr_prescale u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_wr || presc_wr || reload),
    .active(active),
    .code  (presc_code),
    .tick  (tick)
  );

  ltmr_counter #(
    .COUNT_W(COUNT_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_wr),
    .load_value (bus_wdata[COUNT_W-1:0]),
    .start_value(start_value),
    .repeat_en  (lvt_repeat),
    .tick       (tick),
    .count      (live_count),
    .hit_zero   (hit_zero),
    .reload     (reload),
    .active     (active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_req    <= hit_zero && !lvt_mask;
      irq_vector <= (hit_zero && !lvt_mask) ? lvt_vector : '0;
    end
  end

endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker #(
  parameter int COUNT_W = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq_req,
  input logic [7:0]         irq_vector,
  input logic [COUNT_W-1:0] live_count,
  input logic               lvt_mask,
  input logic               lvt_repeat,
  input logic [7:0]         lvt_vector
);

  logic start_wr;
  assign start_wr = bus_wr && (bus_addr == ADDR_W'(1));

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> live_count == $past(bus_wdata[COUNT_W-1:0])); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count != '0 && !start_wr) |=>
      (live_count == $past(live_count) || live_count == $past(live_count) - COUNT_W'(1))); // R4

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == '0 && !lvt_repeat && !start_wr) |=> live_count == '0); // R5

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(lvt_mask)); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req); // R8

  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vector == $past(lvt_vector)); // R8

  AST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> live_count == '0); // R8

endmodule

bind ltmr_top ltmr_checker #(
  .COUNT_W(COUNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_ltmr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_req   (irq_req),
  .irq_vector(irq_vector),
  .live_count(live_count),
  .lvt_mask  (lvt_mask),
  .lvt_repeat(lvt_repeat),
  .lvt_vector(lvt_vector)
);

// File: tb/test_ltmr_top.sv
`timescale 1ns/1ps
module test_ltmr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ltmr_top i_ltmr_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_vector(irq_vector)
  );

  // ---------------- behavioural reference model ----------------
  longint m_cur, m_start, m_pre;
  bit     m_exp, m_mask, m_rep, m_irq;
  int     m_vec, m_vector;
  logic [3:0] m_presc;
  bit     n_irq;
  int     n_vec;

  function automatic int divisor(input logic [3:0] r);
    int code;
    code = {r[3], r[1:0]};
    return (code == 7) ? 1 : (2 << code);
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: begin v[7:0] = m_vector[7:0]; v[16] = m_mask; v[17] = m_rep; end
      2'd1: v = m_start[31:0];
      2'd2: v = m_cur[31:0];
      default: v[3:0] = m_presc;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_cur = 0; m_start = 0; m_pre = 0; m_exp = 0;
      m_mask = 1; m_rep = 0; m_irq = 0; m_vec = 0; m_vector = 0; m_presc = 0;
    end else begin
      n_irq = 0; n_vec = 0;
      if (bus_wr && bus_addr == 2'd1) begin
        m_cur = bus_wdata; m_pre = 0; m_exp = 0;
      end else if (m_exp && m_rep && m_start != 0) begin
        m_cur = m_start; m_pre = 0; m_exp = 0;
      end else if (m_cur != 0) begin
        m_exp = 0;
        m_pre = m_pre + 1;
        if (m_pre >= divisor(m_presc)) begin
          m_pre = 0;
          m_cur = m_cur - 1;
          if (m_cur == 0) begin
            m_exp = 1;
            if (!m_mask) begin n_irq = 1; n_vec = m_vector; end
          end
        end
      end else begin
        m_exp = 0;
      end
      if (bus_wr && bus_addr == 2'd3) begin m_presc = bus_wdata[3:0]; m_pre = 0; end
      if (bus_wr && bus_addr == 2'd0) begin
        m_vector = bus_wdata[7:0]; m_mask = bus_wdata[16]; m_rep = bus_wdata[17];
      end
      if (bus_wr && bus_addr == 2'd1) m_start = bus_wdata;
      m_irq = n_irq; m_vec = n_vec;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq_req == m_irq, "R8 model irq_req", irq_req, m_irq);
      check(irq_vector == m_vec[7:0], "R8 model irq_vector", irq_vector, m_vec);
      check(bus_rdata == model_read(bus_addr), "R3 model read data", bus_rdata, model_read(bus_addr));
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_addr = 2'd2;
  endtask

  // cycles from the write edge until irq_req is seen
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!irq_req && n < limit);
  endtask

  task automatic count_irqs(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (irq_req) n++;
    end
  endtask

  logic [31:0] rv, rv2;
  int n, k;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, rv); check(rv == 32'h0001_0000, "R1 entry after reset", rv, 32'h0001_0000);
    rd(2'd1, rv); check(rv == 0, "R1 start after reset", rv, 0);
    rd(2'd2, rv); check(rv == 0, "R1 live after reset", rv, 0);
    rd(2'd3, rv); check(rv == 0, "R1 presc after reset", rv, 0);
    check(irq_req == 0, "R1 irq after reset", irq_req, 0);

    // R4 R5 R8: divide by 1, single mode, vector 0x41
    wr(2'd3, 32'h0000_000B);
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 5);
    wait_irq(100, n); check(n == 5, "R4 latency div1 N5", n, 5);
    check(irq_vector == 8'h41, "R8 vector with request", irq_vector, 8'h41);
    count_irqs(30, k); check(k == 0, "R5 single mode no repeat", k, 0);
    rd(2'd2, rv); check(rv == 0, "R5 stays at zero", rv, 0);

    // R4 other prescale codes
    wr(2'd3, 32'h0); wr(2'd1, 3);
    wait_irq(200, n); check(n == 6, "R4 latency div2 N3", n, 6);
    wr(2'd3, 32'h2); wr(2'd1, 2);
    wait_irq(200, n); check(n == 16, "R4 latency div8 N2", n, 16);
    wr(2'd3, 32'h3); wr(2'd1, 2);
    wait_irq(200, n); check(n == 32, "R4 latency div16 N2", n, 32);
    wr(2'd3, 32'hA); wr(2'd1, 1);
    wait_irq(300, n); check(n == 128, "R4 latency div128 N1", n, 128);

    // R6 repeat mode
    wr(2'd3, 32'hB);
    wr(2'd0, 32'h0002_0052);
    wr(2'd1, 4);
    wait_irq(100, n); check(n == 4, "R6 first expiry", n, 4);
    wait_irq(100, n); check(n == 5, "R6 period div1 N4", n, 5);
    check(irq_vector == 8'h52, "R8 vector in repeat", irq_vector, 8'h52);
    wr(2'd3, 32'h0); wr(2'd1, 3);
    wait_irq(100, n); check(n == 6, "R6 first expiry div2", n, 6);
    wait_irq(100, n); check(n == 7, "R6 period div2 N3", n, 7);

    // R7 masked shutdown: count keeps running
    wr(2'd0, 32'h0003_0052);
    wr(2'd3, 32'hB);
    wr(2'd1, 6);
    count_irqs(40, k); check(k == 0, "R7 masked no request", k, 0);
    rd(2'd2, rv); rd(2'd2, rv2);
    check(rv != rv2, "R7 masked count still moving", rv2, rv);

    // R3 live-count writes ignored
    wr(2'd0, 32'h0002_0052);
    wr(2'd1, 20);
    wr(2'd2, 32'h0);
    rd(2'd2, rv); check(rv == 17, "R3 write to live ignored", rv, 17);
    rd(2'd1, rv); check(rv == 20, "R3 start unchanged", rv, 20);

    // R2 restart by rewrite
    wr(2'd1, 10);
    repeat (5) @(posedge clk);
    wr(2'd1, 10);
    wait_irq(100, n); check(n == 10, "R2 restart latency", n, 10);

    // R9 zero start value stops, even in repeat mode
    wr(2'd1, 0);
    count_irqs(30, k); check(k == 0, "R9 zero start no request", k, 0);
    rd(2'd2, rv); check(rv == 0, "R9 count stopped", rv, 0);

    // R10 prescale bit 2 kept but without effect, upper bits dropped
    wr(2'd0, 32'h0000_0033);
    wr(2'd3, 32'h0000_000F);
    rd(2'd3, rv); check(rv == 32'hF, "R10 readback bit2 set", rv, 32'hF);
    wr(2'd1, 3);
    wait_irq(100, n); check(n == 3, "R10 bit2 ignored div1", n, 3);
    wr(2'd3, 32'hFFFF_FFF4);
    rd(2'd3, rv); check(rv == 32'h4, "R10 upper bits read zero", rv, 32'h4);
    wr(2'd1, 3);
    wait_irq(100, n); check(n == 6, "R10 bit2 ignored div2", n, 6);

    repeat (5) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule